// File: doc/BRIEF.md
# Instruction Cycle Phase Sequencer

This block is the hardwired control unit of a small accumulator machine. It walks the machine through its instruction cycle and, in every clock period, drives the register-transfer strobes that move a word between the program counter, the address and buffer registers, the instruction register and the accumulator, together with the memory read and write commands. The surrounding datapath owns the registers themselves and the two fixed addresses used on interrupt entry: the save slot and the handler entry.

The current phase is kept in two flag bits (fetch, indirect, execute, interrupt) and the position inside the phase in a small step counter. Each step lasts one clock period, except that a step which reads or writes memory stays where it is until memory signals ready. Transfers that do not interfere share a step, such as the instruction read and the PC increment. Transfers that would use one register as both source and destination, or that need an address not yet in the address register, are put in different steps.

Top module: `cu_phase_seq`

## Requirements
- R1: After reset the phase flags read 00 (fetch) and the step counter reads 0, and `pc_to_mar` is the only strobe asserted.
- R2: Fetch (phase 00) runs in three steps: step 0 asserts `pc_to_mar`; step 1 asserts `mem_rd` and, in the cycle `mem_rdy` is high, also `mem_to_mbr` and `pc_inc` together; step 2 asserts `mbr_to_ir`.
- R3: While a memory step sees `mem_rdy` low, the phase and step stay unchanged and only `mem_rd` or `mem_wr` is asserted; the completion strobes of that step appear only in the cycle with `mem_rdy` high.
- R4: At the end of fetch step 2 the next phase is 01 (indirect) when `ir_ind` is 1 and 10 (execute) otherwise; the datapath presents the incoming instruction's bits on `ir_ind` and `ir_op` during that step.
- R5: Indirect (phase 01): step 0 asserts `ir_to_mar`, step 1 is a memory read completing with `mem_to_mbr`, step 2 asserts `mbr_adr_to_ir`; the next phase is execute.
- R6: Execute with `ir_op` equal to the load code (default 1): step 0 `ir_to_mar`, step 1 a memory read completing with `mem_to_mbr`, step 2 `mbr_to_ac`.
- R7: Execute with the store code (default 2): step 0 asserts `ir_to_mar` and `ac_to_mbr` together, step 1 asserts `mem_wr` until `mem_rdy`; any other code finishes execute in a single step with no strobe.
- R8: When execute ends, the next phase is 11 (interrupt) if `irq` and `int_en` are both 1, and 00 (fetch) otherwise.
- R9: Interrupt (phase 11): step 0 asserts `vec_to_mar` and `pc_to_mbr`; step 1 asserts `mem_wr`, and in its `mem_rdy` cycle also `vec_to_pc` and `ien_clr`; the next phase is fetch.
- R10: In no cycle is a register both read by one strobe and written by another, at most one strobe loads MAR and at most one loads MBR, and `mem_rd` and `mem_wr` are never both high.
- R11: A memory read or write step always directly follows a step that loaded MAR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one step per period |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_ind | input | 1 | Indirect bit of the instruction |
| ir_op | input | OP_W | Opcode of the instruction |
| irq | input | 1 | Interrupt request |
| int_en | input | 1 | Interrupt enable |
| mem_rdy | input | 1 | Memory has completed the current access |
| pc_to_mar | output | 1 | Load MAR from PC |
| ir_to_mar | output | 1 | Load MAR from IR address field |
| vec_to_mar | output | 1 | Load MAR with the fixed save slot |
| mem_to_mbr | output | 1 | Load MBR from memory data |
| pc_to_mbr | output | 1 | Load MBR from PC |
| ac_to_mbr | output | 1 | Load MBR from accumulator |
| mbr_to_ir | output | 1 | Load whole IR from MBR |
| mbr_adr_to_ir | output | 1 | Load IR address field from MBR address bits |
| mbr_to_ac | output | 1 | Load accumulator from MBR |
| pc_inc | output | 1 | Add one to PC |
| vec_to_pc | output | 1 | Load PC with the handler entry |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| ien_clr | output | 1 | Clear the interrupt enable |
| phase | output | 2 | Phase flags: 00 fetch, 01 indirect, 10 execute, 11 interrupt |
| step | output | STEP_W | Step within the phase, 0 for the first |

## Verification
The two functions that share a cycle are the memory read of fetch and the PC increment, and both must land in the one cycle that `mem_rdy` is high, not in the stall cycles before it; the same holds for the handler load and the enable clear in the interrupt write. The bench provokes this by holding `mem_rdy` low for zero, one and two cycles on every memory step, and it judges each cycle against the full strobe vector, phase and step it expects. Every combination of indirect bit, four opcodes, interrupt request and enable is swept, so the end-of-execute decision also meets every stall length.

// File: rtl/cu_pkg.sv
package cu_pkg;

    typedef enum logic [1:0] {
        PH_FETCH = 2'b00,
        PH_INDIR = 2'b01,
        PH_EXEC  = 2'b10,
        PH_INTR  = 2'b11
    } phase_e;

    typedef struct packed {
        logic pc_to_mar;
        logic ir_to_mar;
        logic vec_to_mar;
        logic mem_to_mbr;
        logic pc_to_mbr;
        logic ac_to_mbr;
        logic mbr_to_ir;
        logic mbr_adr_to_ir;
        logic mbr_to_ac;
        logic pc_inc;
        logic vec_to_pc;
        logic mem_rd;
        logic mem_wr;
        logic ien_clr;
    } xfer_t;

endpackage

// File: rtl/cu_xfer_decode.sv
module cu_xfer_decode
    import cu_pkg::*;
#(
    parameter int                OP_W     = 4,
    parameter int                STEP_W   = 2,
    parameter logic [OP_W-1:0]   OP_LOAD  = 1,
    parameter logic [OP_W-1:0]   OP_STORE = 2
) (
    input  phase_e              phase,
    input  logic [STEP_W-1:0]   step,
    input  logic [OP_W-1:0]     op,
    input  logic                mem_rdy,
    output xfer_t               xfer,
    output logic                adv,
    output logic                last
);

    localparam logic [STEP_W-1:0] T1 = STEP_W'(0);
    localparam logic [STEP_W-1:0] T2 = STEP_W'(1);

    logic mem_step;

    always_comb begin
        xfer     = '0;
        mem_step = 1'b0;
        last     = 1'b0;
        unique case (phase)
            PH_FETCH: begin
                case (step)
                    T1: xfer.pc_to_mar = 1'b1;
                    T2: begin
                        xfer.mem_rd = 1'b1;
                        mem_step    = 1'b1;
                        if (mem_rdy) begin
                            xfer.mem_to_mbr = 1'b1;
                            xfer.pc_inc     = 1'b1;
                        end
                    end
                    default: begin
                        xfer.mbr_to_ir = 1'b1;
                        last           = 1'b1;
                    end
                endcase
            end
            PH_INDIR: begin
                case (step)
                    T1: xfer.ir_to_mar = 1'b1;
                    T2: begin
                        xfer.mem_rd     = 1'b1;
                        mem_step        = 1'b1;
                        xfer.mem_to_mbr = mem_rdy;
                    end
                    default: begin
                        xfer.mbr_adr_to_ir = 1'b1;
                        last               = 1'b1;
                    end
                endcase
            end
            PH_EXEC: begin
                if (op == OP_LOAD) begin
                    case (step)
                        T1: xfer.ir_to_mar = 1'b1;
                        T2: begin
                            xfer.mem_rd     = 1'b1;
                            mem_step        = 1'b1;
                            xfer.mem_to_mbr = mem_rdy;
                        end
                        default: begin
                            xfer.mbr_to_ac = 1'b1;
                            last           = 1'b1;
                        end
                    endcase
                end else if (op == OP_STORE) begin
                    case (step)
                        T1: begin
                            xfer.ir_to_mar = 1'b1;
                            xfer.ac_to_mbr = 1'b1;
                        end
                        default: begin
                            xfer.mem_wr = 1'b1;
                            mem_step    = 1'b1;
                            last        = 1'b1;
                        end
                    endcase
                end else begin
                    last = 1'b1;
                end
            end
            default: begin
                case (step)
                    T1: begin
                        xfer.vec_to_mar = 1'b1;
                        xfer.pc_to_mbr  = 1'b1;
                    end
                    default: begin
                        xfer.mem_wr = 1'b1;
                        mem_step    = 1'b1;
                        last        = 1'b1;
                        if (mem_rdy) begin
                            xfer.vec_to_pc = 1'b1;
                            xfer.ien_clr   = 1'b1;
                        end
                    end
                endcase
            end
        endcase
        adv = !(mem_step && !mem_rdy);
    end

endmodule

// File: rtl/cu_phase_ctl.sv
module cu_phase_ctl
    import cu_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                last,
    input  logic                ir_ind,
    input  logic                irq,
    input  logic                int_en,
    output phase_e              phase,
    output logic [STEP_W-1:0]   step
);

    localparam logic [STEP_W-1:0] T_MAX = STEP_W'(2);

    typedef struct packed {
        phase_e            phase;
        logic [STEP_W-1:0] step;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (adv) begin
            if (last) begin
                seq_d.step = '0;
                unique case (seq_q.phase)
                    PH_FETCH: seq_d.phase = ir_ind ? PH_INDIR : PH_EXEC;
                    PH_INDIR: seq_d.phase = PH_EXEC;
                    PH_EXEC:  seq_d.phase = (irq && int_en) ? PH_INTR : PH_FETCH;
                    default:  seq_d.phase = PH_FETCH;
                endcase
            end else begin
                seq_d.step = seq_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_FETCH, step: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase = seq_q.phase;
    assign step  = seq_q.step;

    // R3: a stalled memory step keeps both phase and step
    assert_wait_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(seq_q));

    // R2: no phase ever runs past its third step
    assert_step_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.step <= T_MAX);

    // R8: execute hands over to interrupt only with a pending, enabled request
    assert_intr_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_INTR) ##1 (seq_q.phase == PH_INTR) |->
            $past(seq_q.phase == PH_EXEC && irq && int_en));

endmodule

// File: rtl/cu_phase_seq.sv
module cu_phase_seq
    import cu_pkg::*;
#(
    parameter int              OP_W     = 4,
    parameter int              STEP_W   = 2,
    parameter logic [OP_W-1:0] OP_LOAD  = 1,
    parameter logic [OP_W-1:0] OP_STORE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_ind,
    input  logic [OP_W-1:0]   ir_op,
    input  logic              irq,
    input  logic              int_en,
    input  logic              mem_rdy,
    output logic              pc_to_mar,
    output logic              ir_to_mar,
    output logic              vec_to_mar,
    output logic              mem_to_mbr,
    output logic              pc_to_mbr,
    output logic              ac_to_mbr,
    output logic              mbr_to_ir,
    output logic              mbr_adr_to_ir,
    output logic              mbr_to_ac,
    output logic              pc_inc,
    output logic              vec_to_pc,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              ien_clr,
    output logic [1:0]        phase,
    output logic [STEP_W-1:0] step
);

    phase_e            ph_w;
    logic [STEP_W-1:0] st_w;
    xfer_t             xf;
    logic              adv_w;
    logic              last_w;

    cu_phase_ctl #(.STEP_W(STEP_W)) u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv_w),
        .last   (last_w),
        .ir_ind (ir_ind),
        .irq    (irq),
        .int_en (int_en),
        .phase  (ph_w),
        .step   (st_w)
    );

    cu_xfer_decode #(
        .OP_W     (OP_W),
        .STEP_W   (STEP_W),
        .OP_LOAD  (OP_LOAD),
        .OP_STORE (OP_STORE)
    ) u_dec (
        .phase   (ph_w),
        .step    (st_w),
        .op      (ir_op),
        .mem_rdy (mem_rdy),
        .xfer    (xf),
        .adv     (adv_w),
        .last    (last_w)
    );

    assign pc_to_mar     = xf.pc_to_mar;
    assign ir_to_mar     = xf.ir_to_mar;
    assign vec_to_mar    = xf.vec_to_mar;
    assign mem_to_mbr    = xf.mem_to_mbr;
    assign pc_to_mbr     = xf.pc_to_mbr;
    assign ac_to_mbr     = xf.ac_to_mbr;
    assign mbr_to_ir     = xf.mbr_to_ir;
    assign mbr_adr_to_ir = xf.mbr_adr_to_ir;
    assign mbr_to_ac     = xf.mbr_to_ac;
    assign pc_inc        = xf.pc_inc;
    assign vec_to_pc     = xf.vec_to_pc;
    assign mem_rd        = xf.mem_rd;
    assign mem_wr        = xf.mem_wr;
    assign ien_clr       = xf.ien_clr;
    assign phase         = ph_w;
    assign step          = st_w;

    // R1: first cycle out of reset is fetch step 0
    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (phase == 2'b00 && step == '0));

    // R10: single source for MAR and for MBR
    assert_mar_one_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_to_mar, ir_to_mar, vec_to_mar}));
    assert_mbr_one_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_to_mbr, pc_to_mbr, ac_to_mbr}));

    // R10: a register is never read and written in the same step
    assert_pc_no_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_to_mbr |-> !(pc_inc || vec_to_pc));
    assert_mbr_no_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_to_mbr || pc_to_mbr || ac_to_mbr) |-> !(mbr_to_ir || mbr_adr_to_ir || mbr_to_ac));
    assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11: a memory access starts only right after a MAR load
    assert_rd_after_mar_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> $past(pc_to_mar || ir_to_mar || vec_to_mar));
    assert_wr_after_mar_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> $past(pc_to_mar || ir_to_mar || vec_to_mar));

    // R2: the PC increment rides on the completing fetch read
    assert_inc_with_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |-> (mem_to_mbr && mem_rd && phase == 2'b00));

    // R9: enable is cleared only by the completing interrupt save
    assert_ien_clr_in_intr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ien_clr |-> (phase == 2'b11 && mem_wr && mem_rdy && vec_to_pc));

endmodule

// File: tb/cu_phase_seq_bench.sv
module cu_phase_seq_bench;

    localparam int CLK_PERIOD = 10;

    localparam logic [13:0] S_PCMAR  = 14'b1 << 13;
    localparam logic [13:0] S_IRMAR  = 14'b1 << 12;
    localparam logic [13:0] S_VECMAR = 14'b1 << 11;
    localparam logic [13:0] S_MEMMBR = 14'b1 << 10;
    localparam logic [13:0] S_PCMBR  = 14'b1 << 9;
    localparam logic [13:0] S_ACMBR  = 14'b1 << 8;
    localparam logic [13:0] S_IR     = 14'b1 << 7;
    localparam logic [13:0] S_ADRIR  = 14'b1 << 6;
    localparam logic [13:0] S_AC     = 14'b1 << 5;
    localparam logic [13:0] S_PCINC  = 14'b1 << 4;
    localparam logic [13:0] S_VECPC  = 14'b1 << 3;
    localparam logic [13:0] S_RD     = 14'b1 << 2;
    localparam logic [13:0] S_WR     = 14'b1 << 1;
    localparam logic [13:0] S_IENCLR = 14'b1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_ind = 1'b0;
    logic [3:0] ir_op = '0;
    logic       irq = 1'b0;
    logic       int_en = 1'b0;
    logic       mem_rdy = 1'b0;
    logic       pc_to_mar, ir_to_mar, vec_to_mar, mem_to_mbr, pc_to_mbr, ac_to_mbr;
    logic       mbr_to_ir, mbr_adr_to_ir, mbr_to_ac, pc_inc, vec_to_pc;
    logic       mem_rd, mem_wr, ien_clr;
    logic [1:0] phase;
    logic [1:0] step;

    int vectors = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cu_phase_seq u_cu_phase_seq (
        .clk(clk), .rst_n(rst_n), .ir_ind(ir_ind), .ir_op(ir_op), .irq(irq),
        .int_en(int_en), .mem_rdy(mem_rdy),
        .pc_to_mar(pc_to_mar), .ir_to_mar(ir_to_mar), .vec_to_mar(vec_to_mar),
        .mem_to_mbr(mem_to_mbr), .pc_to_mbr(pc_to_mbr), .ac_to_mbr(ac_to_mbr),
        .mbr_to_ir(mbr_to_ir), .mbr_adr_to_ir(mbr_adr_to_ir), .mbr_to_ac(mbr_to_ac),
        .pc_inc(pc_inc), .vec_to_pc(vec_to_pc), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ien_clr(ien_clr), .phase(phase), .step(step)
    );

    function automatic logic [13:0] strobes();
        return {pc_to_mar, ir_to_mar, vec_to_mar, mem_to_mbr, pc_to_mbr, ac_to_mbr,
                mbr_to_ir, mbr_adr_to_ir, mbr_to_ac, pc_inc, vec_to_pc,
                mem_rd, mem_wr, ien_clr};
    endfunction

    task automatic compare(input logic [1:0] eph, input logic [1:0] est,
                           input logic [13:0] exp_s, input string tag);
        vectors++;
        if (strobes() !== exp_s || phase !== eph || step !== est) begin
            fails++;
            $display("FAIL %s: got strobes %b phase %0d step %0d, expected %b phase %0d step %0d",
                     tag, strobes(), phase, step, exp_s, eph, est);
        end
    endtask

    // one clock period: drive ready, check, move to the next falling edge
    task automatic cyc(input logic rdy, input logic [1:0] eph, input logic [1:0] est,
                       input logic [13:0] exp_s, input string tag);
        mem_rdy = rdy;
        #1;
        compare(eph, est, exp_s, tag);
        @(negedge clk);
    endtask

    task automatic mem_step(input logic [1:0] eph, input logic [13:0] base,
                            input logic [13:0] done, input int nw, input string tag);
        for (int w = 0; w < nw; w++) cyc(1'b0, eph, 2'd1, base, "R3 stall");
        cyc(1'b1, eph, 2'd1, base | done, tag);
    endtask

    task automatic run_instr(input logic ind, input logic [3:0] op, input logic rq,
                             input logic en, input int nw);
        ir_ind = ind; ir_op = op; irq = rq; int_en = en;
        cyc(1'b0, 2'd0, 2'd0, S_PCMAR, "R8 next fetch / R2 t1");
        mem_step(2'd0, S_RD, S_MEMMBR | S_PCINC, nw, "R2 read+inc");
        cyc(1'b0, 2'd0, 2'd2, S_IR, "R2 t3");
        if (ind) begin
            cyc(1'b0, 2'd1, 2'd0, S_IRMAR, "R4 / R5 t1");
            mem_step(2'd1, S_RD, S_MEMMBR, nw, "R5 read");
            cyc(1'b0, 2'd1, 2'd2, S_ADRIR, "R5 t3");
        end
        if (op == 4'd1) begin
            cyc(1'b0, 2'd2, 2'd0, S_IRMAR, "R6 t1");
            mem_step(2'd2, S_RD, S_MEMMBR, nw, "R6 read");
            cyc(1'b0, 2'd2, 2'd2, S_AC, "R6 t3");
        end else if (op == 4'd2) begin
            cyc(1'b0, 2'd2, 2'd0, S_IRMAR | S_ACMBR, "R7 store t1");
            mem_step(2'd2, S_WR, '0, nw, "R7 store write");
        end else begin
            cyc(1'b0, 2'd2, 2'd0, '0, "R7 other opcode");
        end
        if (rq && en) begin
            cyc(1'b0, 2'd3, 2'd0, S_VECMAR | S_PCMBR, "R8 / R9 t1");
            mem_step(2'd3, S_WR, S_VECPC | S_IENCLR, nw, "R9 save");
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        compare(2'd0, 2'd0, S_PCMAR, "R1 in reset");
        irq = 1'b1; int_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        irq = 1'b0; int_en = 1'b0;
        #1;
        compare(2'd0, 2'd0, S_PCMAR, "R1 after reset");
        for (int ind = 0; ind < 2; ind++)
            for (int op = 0; op < 4; op++)
                for (int ie = 0; ie < 2; ie++)
                    for (int rq = 0; rq < 2; rq++)
                        for (int nw = 0; nw < 3; nw++)
                            run_instr(ind[0], 4'(op), rq[0], ie[0], nw);
        cyc(1'b0, 2'd0, 2'd0, S_PCMAR, "R8 final fetch");
        // reset in the middle of an indirect read returns to fetch step 0
        run_instr_prefix();
        finish_run();
    end

    task automatic run_instr_prefix();
        ir_ind = 1'b1; ir_op = 4'd1;
        cyc(1'b1, 2'd0, 2'd1, S_RD | S_MEMMBR | S_PCINC, "R2 read");
        cyc(1'b0, 2'd0, 2'd2, S_IR, "R2 t3");
        cyc(1'b0, 2'd1, 2'd0, S_IRMAR, "R4 to indirect");
        mem_rdy = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare(2'd0, 2'd0, S_PCMAR, "R1 mid-cycle reset");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got no completion, expected end of sweep");
        finish_run();
    end

endmodule